// File: doc/BRIEF.md
# Request-Level Status and Completion Register

This block is a small bus-mapped register pair. It reports, as one read-only status word, the state of four request levels owned by a remote processor. The same word carries two high bits of the current command pointer and the local memory size. The status word is inverted relative to the remote summary: a level's bit reads 1 once the remote side has no request pending on it. The level bits sit at scattered positions in the word.

A second register, the control/status register (CSR), holds an interrupt enable and a sticky "all requests done" flag. The status is evaluated when the remote side pulses its summary-update strobe and on every read of the status word. If the summary is all zero at that moment, the done flag sets. If interrupts are enabled, the interrupt output then rises. Software reads the status word through word select 2 and the CSR through word select 0.

Top module: `lvlstat_reg`

## Requirements
- R1: After reset, irq is 0 and a CSR read returns 0x0000 (interrupt enable 0, done flag 0).
- R2: Status word bits 1:0 equal command pointer bits 16:15.
- R3: Status word bits 10:8 equal the low 3 bits of the memory size input, which counts 4K-word units. Higher input bits are discarded.
- R4: Level 0 reads at status bit 7, level 1 at bit 15, level 2 at bit 6 and level 3 at bit 14. Each bit is the inverse of its reqSummary bit, so 1 means idle.
- R5: Status word bits 5:2 and 13:11 always read 0.
- R6: The done flag (CSR bit 7) sets when the summary is all zero on a cycle with an update strobe or a status read. It does not set while any level is active.
- R7: Once set, the done flag stays set across later reads, summary changes and CSR writes until reset.
- R8: An even-byte CSR write changes only interrupt enable, taken from write data bit 6. Odd-byte CSR writes change nothing.
- R9: irq rises on the edge where the done flag sets while enable is 1. It also rises on an enabling CSR write when the done flag is already set.
- R10: An even-byte CSR write with bit 6 = 0 drops irq on that edge. irq is never 1 while enable is 0.
- R11: Read data is registered and appears the cycle after the read strobe. Word selects 1 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqSummary | input | 4 | Remote active-request summary, 1 = level active |
| updStrobe | input | 1 | Remote pulse: summary has changed |
| cmdPtr | input | 18 | Current command pointer |
| memSize | input | 5 | Local memory size in 4K-word units |
| busSel | input | 2 | Word select: 0 CSR, 2 status |
| busRead | input | 1 | Read strobe |
| busWrite | input | 1 | Write strobe |
| busOddByte | input | 1 | Write targets the odd byte only |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
A stuck or early done flag shows up as CSR bit 7 on the next CSR read. It also shows up as irq rising once interrupts are enabled, one edge after the offending evaluation. A wrong level bit position or a missing inversion shows up directly in the status word on the cycle after its read. The sweep covers all fifteen non-idle summaries to prove that none sets the done flag. A lost enable or a stale interrupt is visible on irq immediately after the CSR write edge.

// File: rtl/lvlstat_pkg.sv
package lvlstat_pkg;
  localparam int LEVELS = 4;
  localparam int LVL_BIT [LEVELS] = '{7, 15, 6, 14};
  localparam logic [1:0] SEL_CSR  = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam int CSR_IE_BIT   = 6;
  localparam int CSR_DONE_BIT = 7;

  typedef struct packed {
    logic evalIdle;
    logic ieWrite;
    logic ieValue;
    logic rdEn;
    logic selCsr;
    logic selStat;
  } ctlStrobe_t;
endpackage

// File: rtl/lvlstat_dp.sv
module lvlstat_dp
  import lvlstat_pkg::*;
#(
  parameter int PTR_W   = 18,
  parameter int PTR_LSB = 15,
  parameter int SIZE_W  = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic [LEVELS-1:0] reqSummary,
  input  logic [PTR_W-1:0]  cmdPtr,
  input  logic [SIZE_W-1:0] memSize,
  input  logic              ieBit,
  input  logic              doneBit,
  output logic              allIdle,
  output logic [DATA_W-1:0] rdata
);
  localparam int PTR_KEEP  = 2;
  localparam int SIZE_KEEP = 3;
  localparam int SIZE_POS  = 8;

  logic [DATA_W-1:0] statWord;
  logic [DATA_W-1:0] csrWord;
  logic unusedInputs;

  assign unusedInputs = ^{cmdPtr, memSize};
  assign allIdle = (reqSummary == '0);

  always_comb begin
    statWord = '0;
    statWord[PTR_KEEP-1:0] = cmdPtr[PTR_LSB +: PTR_KEEP];
    statWord[SIZE_POS +: SIZE_KEEP] = memSize[SIZE_KEEP-1:0];
    for (int i = 0; i < LEVELS; i++) begin
      statWord[LVL_BIT[i]] = ~reqSummary[i];
    end
  end

  always_comb begin
    csrWord = '0;
    csrWord[CSR_IE_BIT]   = ieBit;
    csrWord[CSR_DONE_BIT] = doneBit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (strobe.rdEn) begin
      if (strobe.selStat)     rdata <= statWord;
      else if (strobe.selCsr) rdata <= csrWord;
      else                    rdata <= '0;
    end
  end
endmodule

// File: rtl/lvlstat_ctrl.sv
module lvlstat_ctrl
  import lvlstat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] busSel,
  input  logic       busRead,
  input  logic       busWrite,
  input  logic       busOddByte,
  input  logic       wdataIe,
  input  logic       updStrobe,
  input  logic       allIdle,
  output ctlStrobe_t strobe,
  output logic       ieBit,
  output logic       doneBit,
  output logic       irq
);
  logic setDone;

  always_comb begin
    strobe.rdEn     = busRead;
    strobe.selCsr   = (busSel == SEL_CSR);
    strobe.selStat  = (busSel == SEL_STAT);
    strobe.evalIdle = updStrobe | (busRead & (busSel == SEL_STAT));
    strobe.ieWrite  = busWrite & ~busOddByte & (busSel == SEL_CSR);
    strobe.ieValue  = wdataIe;
  end

  assign setDone = strobe.evalIdle & allIdle & ~doneBit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ieBit   <= 1'b0;
      doneBit <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (setDone) doneBit <= 1'b1;
      if (strobe.ieWrite) begin
        ieBit <= strobe.ieValue;
        irq   <= strobe.ieValue & (doneBit | setDone);
      end else if (setDone & ieBit) begin
        irq <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lvlstat_reg.sv
module lvlstat_reg
  import lvlstat_pkg::*;
#(
  parameter int PTR_W   = 18,
  parameter int PTR_LSB = 15,
  parameter int SIZE_W  = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reqSummary,
  input  logic              updStrobe,
  input  logic [PTR_W-1:0]  cmdPtr,
  input  logic [SIZE_W-1:0] memSize,
  input  logic [1:0]        busSel,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic              busOddByte,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  ctlStrobe_t strobe;
  logic ieBit;
  logic doneBit;
  logic allIdle;
  logic unusedWdata;

  assign unusedWdata = ^busWdata;

  lvlstat_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busRead(busRead),
    .busWrite(busWrite), .busOddByte(busOddByte),
    .wdataIe(busWdata[CSR_IE_BIT]), .updStrobe(updStrobe),
    .allIdle(allIdle), .strobe(strobe), .ieBit(ieBit),
    .doneBit(doneBit), .irq(irq)
  );

  lvlstat_dp #(
    .PTR_W(PTR_W), .PTR_LSB(PTR_LSB), .SIZE_W(SIZE_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqSummary(reqSummary),
    .cmdPtr(cmdPtr), .memSize(memSize), .ieBit(ieBit), .doneBit(doneBit),
    .allIdle(allIdle), .rdata(busRdata)
  );
endmodule

// File: rtl/lvlstat_chk.sv
module lvlstat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  reqSummary,
  input logic        updStrobe,
  input logic [1:0]  busSel,
  input logic        busRead,
  input logic        busWrite,
  input logic        busOddByte,
  input logic [15:0] busWdata,
  input logic [15:0] busRdata,
  input logic        irq,
  input logic        ieBit,
  input logic        doneBit
);
  logic statRead;
  logic ieClear;
  assign statRead = busRead && busSel == 2'd2;
  assign ieClear  = busWrite && !busOddByte && busSel == 2'd0 && !busWdata[6];

  p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (updStrobe || statRead) && reqSummary == 4'd0 |=> doneBit);

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    doneBit |=> doneBit);

  p_irq_needs_ie_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ieBit);

  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ieClear |=> !irq);

  p_level_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    statRead |=> busRdata[7] == !$past(reqSummary[0]) && busRdata[15] == !$past(reqSummary[1])
              && busRdata[6] == !$past(reqSummary[2]) && busRdata[14] == !$past(reqSummary[3]));

  p_unused_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    statRead |=> busRdata[5:2] == 4'd0 && busRdata[13:11] == 3'd0);
endmodule

bind lvlstat_reg lvlstat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reqSummary(reqSummary), .updStrobe(updStrobe),
  .busSel(busSel), .busRead(busRead), .busWrite(busWrite),
  .busOddByte(busOddByte), .busWdata(busWdata), .busRdata(busRdata),
  .irq(irq), .ieBit(ieBit), .doneBit(doneBit)
);

// File: tb/lvlstat_reg_tb.sv
module lvlstat_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reqSummary = 4'hF;
  logic        updStrobe = 1'b0;
  logic [17:0] cmdPtr = '0;
  logic [4:0]  memSize = '0;
  logic [1:0]  busSel = '0;
  logic        busRead = 1'b0;
  logic        busWrite = 1'b0;
  logic        busOddByte = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lvlstat_reg u_dut (
    .clk(clk), .rst_n(rst_n), .reqSummary(reqSummary), .updStrobe(updStrobe),
    .cmdPtr(cmdPtr), .memSize(memSize), .busSel(busSel), .busRead(busRead),
    .busWrite(busWrite), .busOddByte(busOddByte), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expStat(input logic [3:0] s, input logic [17:0] p, input logic [4:0] m);
    logic [15:0] w;
    w = '0;
    w[1:0]  = p[16:15];
    w[10:8] = m[2:0];
    w[7]  = !s[0];
    w[15] = !s[1];
    w[6]  = !s[2];
    w[14] = !s[3];
    return w;
  endfunction

  task automatic doRead(input logic [1:0] sel, output logic [15:0] d);
    @(negedge clk);
    busSel = sel; busRead = 1'b1;
    @(negedge clk);
    busRead = 1'b0;
    d = busRdata;
  endtask

  task automatic doWrite(input logic odd, input logic [15:0] data);
    @(negedge clk);
    busSel = 2'd0; busWrite = 1'b1; busOddByte = odd; busWdata = data;
    @(negedge clk);
    busWrite = 1'b0; busOddByte = 1'b0;
  endtask

  task automatic pulseUpdate();
    @(negedge clk);
    updStrobe = 1'b1;
    @(negedge clk);
    updStrobe = 1'b0;
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    doReset();
    // R1: reset state
    doRead(2'd0, d);
    check("R1 csr", d, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);

    // R2 R3 R4 R5: sweep of every non-idle summary with pointer and size variants
    for (int s = 1; s < 16; s++) begin
      for (int j = 0; j < 8; j++) begin
        reqSummary = 4'(s);
        memSize = 5'(j + 8 * (s % 4));
        cmdPtr = 18'((s * 18'h2345 + j * 18'h1B1F) & 18'h3FFFF);
        doRead(2'd2, d);
        check("R2 R3 R4 R5 status", d, expStat(reqSummary, cmdPtr, memSize));
      end
      pulseUpdate();
    end
    // R6: no done flag while any level active
    doRead(2'd0, d);
    check("R6 no done while active", d, 16'h0000);

    // R8: odd-byte write ignored, even write takes only bit 6
    doWrite(1'b1, 16'hFFFF);
    doRead(2'd0, d);
    check("R8 odd ignored", d, 16'h0000);
    doWrite(1'b0, 16'hFFFF);
    doRead(2'd0, d);
    check("R8 ie only", d, 16'h0040);
    check("R9 no irq before done", {15'd0, irq}, 16'h0000);

    // R6 R9: update strobe with all idle sets done and raises irq
    reqSummary = 4'h0;
    pulseUpdate();
    check("R9 irq on done", {15'd0, irq}, 16'h0001);
    doRead(2'd0, d);
    check("R6 done set", d, 16'h00C0);

    // R7: done persists after activity and status read
    reqSummary = 4'hF;
    doRead(2'd2, d);
    check("R4 all active", d, expStat(4'hF, cmdPtr, memSize));
    pulseUpdate();
    doRead(2'd0, d);
    check("R7 done sticky", d, 16'h00C0);

    // R10: clearing enable drops irq, done stays
    doWrite(1'b0, 16'hFFBF);
    check("R10 irq drop", {15'd0, irq}, 16'h0000);
    doRead(2'd0, d);
    check("R7 done after ie clear", d, 16'h0080);

    // R9: enabling with done already set raises irq
    doWrite(1'b0, 16'h0040);
    check("R9 irq on enable", {15'd0, irq}, 16'h0001);

    // R8: odd write with zero leaves irq and ie
    doWrite(1'b1, 16'h0000);
    check("R8 odd no effect irq", {15'd0, irq}, 16'h0001);
    doRead(2'd0, d);
    check("R8 odd no effect csr", d, 16'h00C0);

    // R11: unused selects read 0
    doRead(2'd1, d);
    check("R11 sel1", d, 16'h0000);
    doRead(2'd3, d);
    check("R11 sel3", d, 16'h0000);

    // R6: status read with all idle sets done without enable
    reqSummary = 4'hF;
    doReset();
    reqSummary = 4'h0;
    cmdPtr = 18'h18000;
    memSize = 5'd5;
    doRead(2'd2, d);
    check("R4 all idle", d, expStat(4'h0, cmdPtr, memSize));
    check("R10 no irq without ie", {15'd0, irq}, 16'h0000);
    doRead(2'd0, d);
    check("R6 done by read", d, 16'h0080);
    doWrite(1'b0, 16'h0040);
    check("R9 enable after read-done", {15'd0, irq}, 16'h0001);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule